// File: doc/BRIEF.md
# External Clock Failure Supervisor

This block supervises an external crystal oscillator from a free-running reference clock. It brings the external clock into the reference domain through a short synchronizer chain and looks for its rising edges. If an armed detector sees no rising edge for a set number of reference cycles, it declares a failure.

A failure does four things. It requests that the external oscillator be switched off. It sends a one-cycle break event to the advanced-control timers. It raises a sticky interrupt flag that is routed as non-maskable. If the external clock was driving the system clock, directly or as the PLL input, it also forces the system clock over to an internal fallback source chosen by a configuration bit.

The detector arms only when all of these are true: software has enabled monitoring, the oscillator is enabled, and the oscillator has signalled the end of its startup delay. After a failure it stays disarmed until the oscillator is switched off and then brought up again.

Top module: `ext_clk_supervisor`

## Requirements
- R1: Out of reset, every output is 0. This covers `osc_off_req`, `brk_pulse`, `nmi_flag`, `fb_force` and `fb_src`.
- R2: No failure is declared unless `mon_en`, `osc_on` and `osc_rdy` are all 1. If any of them is 0, a stopped external clock produces no outputs.
- R3: While armed, a failure is declared when 16 consecutive reference cycles pass without a rising edge of the synchronized external clock. A rising edge at least once every 16 reference cycles never causes a failure. The failure outputs rise at the 16th clock edge after arming on a stopped clock.
- R4: `brk_pulse` is high for exactly one reference cycle per failure.
- R5: `nmi_flag` sets on a failure and stays set until `clr_w1c` is 1 for a cycle, after which it reads 0. If a failure and a clear happen in the same cycle, the failure wins.
- R6: Asserting `clr_w1c` while `nmi_flag` is 0 changes no output.
- R7: `osc_off_req` sets on a failure and holds until `osc_on` goes to 0.
- R8: After a failure, no further failure is declared until `osc_on` has been 0 and the oscillator is enabled and ready again.
- R9: `fb_force` pulses together with `brk_pulse` only if `sys_on_ext` is 1 at the failure. `fb_src` captures `fb_sel` at each failure and holds it. A value of 0 selects the multi-speed oscillator and 1 selects the 16 MHz internal oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Software enable for monitoring |
| osc_on | input | 1 | External oscillator enabled |
| osc_rdy | input | 1 | External oscillator startup complete |
| ext_clk_in | input | 1 | External clock, asynchronous to `clk` |
| sys_on_ext | input | 1 | External clock feeds the system clock (directly or via PLL) |
| fb_sel | input | 1 | Fallback choice: 0 multi-speed, 1 16 MHz internal |
| clr_w1c | input | 1 | Write-one-to-clear for the interrupt flag |
| osc_off_req | output | 1 | Request to disable the external oscillator |
| brk_pulse | output | 1 | One-cycle break event to the timers |
| nmi_flag | output | 1 | Sticky non-maskable interrupt flag |
| fb_force | output | 1 | One-cycle forced switch to the fallback source |
| fb_src | output | 1 | Fallback source captured at failure |

## Verification
The main detection path is driven with the external clock toggling at half-periods of 1, 2, 4, 8, 9 and 12 reference cycles, and with the clock stuck low. The 8 and 9 cycle cases sit on either side of the 16-cycle miss window, so they tell a correctly sized window from one that is off by one. The faster rates show that frequent edges keep resetting the window. The stuck and slow cases must each produce exactly one break pulse, which also shows the lockout after a failure. Directed cases then cover:
- the exact cycle in which a failure is declared;
- each of the arming conditions;
- a clear that arrives in the same cycle as a failure;
- a clear with nothing pending;
- the fallback source and whether the fallback switch is forced at all.

// File: rtl/ext_clk_supervisor.sv
module ext_clk_supervisor #(
  parameter int unsigned MISS_LIMIT  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic osc_on,
  input  logic osc_rdy,
  input  logic ext_clk_in,
  input  logic sys_on_ext,
  input  logic fb_sel,
  input  logic clr_w1c,
  output logic osc_off_req,
  output logic brk_pulse,
  output logic nmi_flag,
  output logic fb_force,
  output logic fb_src
);

  localparam int unsigned CW = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        miss_cnt;
  logic                 armed, rise, fail;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_in};

  assign rise  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign armed = mon_en & osc_on & osc_rdy & ~osc_off_req;
  assign fail  = armed & ~rise & (miss_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 miss_cnt <= '0;
    else if (!armed || rise || fail) miss_cnt <= '0;
    else                        miss_cnt <= miss_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      osc_off_req <= 1'b0;
      brk_pulse   <= 1'b0;
      nmi_flag    <= 1'b0;
      fb_force    <= 1'b0;
      fb_src      <= 1'b0;
    end else begin
      brk_pulse <= fail;
      fb_force  <= fail & sys_on_ext;
      if (fail)         fb_src <= fb_sel;
      if (fail)         osc_off_req <= 1'b1;
      else if (!osc_on) osc_off_req <= 1'b0;
      if (fail)         nmi_flag <= 1'b1;
      else if (clr_w1c) nmi_flag <= 1'b0;
    end

  a_r4_brk_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);
  a_r7_off_with_brk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> osc_off_req);
  a_r5_nmi_with_brk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> nmi_flag);
  a_r5_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !clr_w1c) |=> nmi_flag);
  a_r2_no_brk_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en || !osc_rdy) |=> !brk_pulse);
  a_r9_force_only_on_brk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_force |-> brk_pulse);
  a_r8_locked_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off_req |=> !brk_pulse);

endmodule

// File: tb/ext_clk_supervisor_bench.sv
module ext_clk_supervisor_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mon_en = 0, osc_on = 0, osc_rdy = 0, ext_clk_in = 0;
  logic sys_on_ext = 0, fb_sel = 0, clr_w1c = 0;
  logic osc_off_req, brk_pulse, nmi_flag, fb_force, fb_src;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_clk_supervisor u_ext_clk_supervisor (.*);

  // {half-period in reference cycles (0 = stuck low), expected break pulse count}
  localparam int VEC [7][2] = '{'{1,0}, '{2,0}, '{4,0}, '{8,0}, '{9,1}, '{12,1}, '{0,1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rearm();
    osc_on = 0; clr_w1c = 1; step(); clr_w1c = 0; ext_clk_in = 0;
    osc_on = 1; osc_rdy = 1; mon_en = 1;
  endtask

  task automatic run_clock(input int hp, input int n, output int pulses);
    int ph = 0;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      if (hp != 0) begin
        ph++;
        if (ph == hp) begin ext_clk_in = ~ext_clk_in; ph = 0; end
      end
      step();
      if (brk_pulse) pulses++;
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(done, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p;
    step(2);
    // R1
    chk({osc_off_req, brk_pulse, nmi_flag, fb_force, fb_src} == 5'b0, "R1 reset",
        {osc_off_req, brk_pulse, nmi_flag, fb_force, fb_src}, 0);
    rst_n = 1; step(2);
    chk({osc_off_req, brk_pulse, nmi_flag, fb_force, fb_src} == 5'b0, "R1 after release",
        {osc_off_req, brk_pulse, nmi_flag, fb_force, fb_src}, 0);

    // R3 R4 R8 vector table
    foreach (VEC[k]) begin
      rearm();
      run_clock(VEC[k][0], 120, p);
      chk(p == VEC[k][1], $sformatf("R3/R8 hp=%0d", VEC[k][0]), p, VEC[k][1]);
    end

    // R2 disarmed cases
    rearm(); mon_en = 0; run_clock(0, 40, p);
    chk(p == 0 && !nmi_flag, "R2 monitor disabled", p, 0);
    rearm(); osc_rdy = 0; run_clock(0, 40, p);
    chk(p == 0 && !nmi_flag, "R2 not ready", p, 0);

    // R3 exact timing, R9 with fallback to 16 MHz source
    rearm(); sys_on_ext = 1; fb_sel = 1;
    step(15);
    chk(!brk_pulse && !nmi_flag, "R3 no fail at 15", brk_pulse, 0);
    step();
    chk(brk_pulse && nmi_flag && osc_off_req, "R3 fail at 16", brk_pulse, 1);
    chk(fb_force && fb_src, "R9 force to 16 MHz", {fb_force, fb_src}, 3);
    fb_sel = 0; step();
    chk(!brk_pulse && !fb_force, "R4 single pulse", brk_pulse, 0);
    chk(fb_src == 1, "R9 source held", fb_src, 1);
    step(10);
    chk(nmi_flag, "R5 sticky", nmi_flag, 1);
    chk(osc_off_req, "R7 off held", osc_off_req, 1);
    clr_w1c = 1; step(); clr_w1c = 0;
    chk(!nmi_flag, "R5 cleared", nmi_flag, 0);
    osc_on = 0; step();
    chk(!osc_off_req, "R7 off released", osc_off_req, 0);

    // R6 clear with nothing pending
    clr_w1c = 1; step(); clr_w1c = 0;
    chk({osc_off_req, brk_pulse, nmi_flag, fb_force} == 4'b0, "R6 idle clear",
        {osc_off_req, brk_pulse, nmi_flag, fb_force}, 0);

    // R5 clear coincident with failure; R9 no force when not on external
    rearm(); sys_on_ext = 0; fb_sel = 0;
    step(15); clr_w1c = 1; step(); clr_w1c = 0;
    chk(nmi_flag && brk_pulse, "R5 fail beats clear", nmi_flag, 1);
    chk(!fb_force && fb_src == 0, "R9 no force off external", {fb_force, fb_src}, 0);

    // R9 fallback to multi-speed oscillator
    rearm(); sys_on_ext = 1; fb_sel = 0; step(16);
    chk(fb_force && fb_src == 0, "R9 force to multi-speed", {fb_force, fb_src}, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule